// File: doc/BRIEF.md
# Pipelined GF(2^163) Polynomial-Basis Multiplier

This block multiplies two elements of the binary field GF(2^163) in polynomial basis. It returns C = A·B reduced modulo the field polynomial x^163 + x^7 + x^6 + x^3 + 1. It is the arithmetic core of an elliptic-curve datapath. The operand pair arrives with a valid strobe, and the reduced product leaves with its own valid strobe after a fixed number of register stages.

The product is built column by column. Column j is the multiplicand shifted j times modulo the field polynomial, and it is kept only when bit j of B is set. The columns are split across `STAGES` register stages. Each stage holds a chain of shift-and-reduce cells and an XOR accumulator. It hands three values to the next stage: the shifted multiplicand, the running partial sum and the B operand. Nothing flows backwards through the pipeline, so a fresh operand pair can enter on every clock.

Top module: `gf2m_pipe_mul`

## Requirements
- R1: Reduction uses G(x) = x^163 + x^7 + x^6 + x^3 + 1. Bit i of a bus is the coefficient of x^i. For example, x^162 multiplied by x gives the value with bits 7, 6, 3 and 0 set (hex C9).
- R2: For any operands a_i and b_i of 163 bits, prod_o equals a_i·b_i mod G(x).
- R3: Operands sampled with valid_i high at rising edge n appear on prod_o, with valid_o high, right after rising edge n+STAGES-1. That is one register per stage, and STAGES defaults to 4.
- R4: A new operand pair may be presented on every cycle. Back-to-back pairs come out on consecutive cycles, in their input order.
- R5: valid_o is low while rst_ni is low and stays low once reset ends. A result in flight when reset is asserted is discarded. After any valid_i gap, valid_o is low on the matching cycles.
- R6: If either operand is zero, the product is zero.
- R7: If either operand equals 1, the product equals the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair valid |
| a_i | input | 163 | Multiplicand |
| b_i | input | 163 | Multiplier |
| valid_o | output | 1 | Product valid |
| prod_o | output | 163 | Reduced product |

## Verification
The bench multiplies x^162 by x and by x^162, and all-ones by itself, so that the top bit overflows in every stage. A wrong tap set or a missing reduction would show up there as a wrong low-order pattern. Operands of 0 and 1, and values of B with only bit 0 or only bit 162 set, test the column at each end of the matrix. A stage boundary that drops or repeats a column would corrupt exactly those results. Back-to-back random streams with gaps, plus a reset that lands while results are in flight, expose a skewed B pipeline or a misaligned valid chain. Either fault would pair a product with the wrong strobe or let a discarded result out.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  localparam int unsigned FIELD_W = 163;
  // low-order terms of G(x): x^7 + x^6 + x^3 + 1
  localparam logic [FIELD_W-1:0] FIELD_TAPS = FIELD_W'('hC9);
endpackage

// File: rtl/gf2m_shift_cell.sv
module gf2m_shift_cell #(
  parameter int unsigned WIDTH = 163,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'('hC9)
) (
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] out_o
);
  assign out_o = {in_i[WIDTH-2:0], 1'b0} ^ (in_i[WIDTH-1] ? TAPS : '0);
endmodule

// File: rtl/gf2m_mul_stage.sv
module gf2m_mul_stage #(
  parameter int unsigned WIDTH = 163,
  parameter int unsigned COLS  = 41,
  parameter int unsigned BASE  = 0,
  parameter logic [WIDTH-1:0] TAPS = WIDTH'('hC9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] alpha_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] alpha_o,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] b_o
);
  logic [WIDTH-1:0] chain [COLS+1];
  logic [WIDTH-1:0] term  [1:COLS];
  logic [WIDTH-1:0] acc;

  assign chain[0] = alpha_i;

  for (genvar k = 1; k <= COLS; k++) begin : g_col
    gf2m_shift_cell #(.WIDTH(WIDTH), .TAPS(TAPS)) u_cell (
      .in_i (chain[k-1]),
      .out_o(chain[k])
    );
    if (BASE + k < WIDTH) begin : g_live
      assign term[k] = b_i[BASE+k] ? chain[k] : '0;
    end else begin : g_pad
      assign term[k] = '0;
    end
  end

  always_comb begin
    acc = sum_i;
    for (int k = 1; k <= COLS; k++) acc ^= term[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      alpha_o <= '0;
      sum_o   <= '0;
      b_o     <= '0;
    end else begin
      valid_o <= valid_i;
      alpha_o <= chain[COLS];
      sum_o   <= acc;
      b_o     <= b_i;
    end
  end
endmodule

// File: rtl/gf2m_pipe_mul.sv
module gf2m_pipe_mul #(
  parameter int unsigned WIDTH  = gf2m_pkg::FIELD_W,
  parameter int unsigned STAGES = 4,
  parameter logic [WIDTH-1:0] TAPS = gf2m_pkg::FIELD_TAPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] prod_o
);
  // columns 1..WIDTH-1 split over the stages; column 0 seeds the sum
  localparam int unsigned COLS = (WIDTH - 1 + STAGES - 1) / STAGES;

  logic             v_s     [STAGES];
  logic [WIDTH-1:0] alpha_s [STAGES];
  logic [WIDTH-1:0] sum_s   [STAGES];
  logic [WIDTH-1:0] b_s     [STAGES];
  logic [WIDTH-1:0] last_alpha_unused;
  logic [WIDTH-1:0] last_b_unused;

  assign v_s[0]     = valid_i;
  assign alpha_s[0] = a_i;
  assign sum_s[0]   = b_i[0] ? a_i : '0;
  assign b_s[0]     = b_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == STAGES - 1) begin : g_last
      gf2m_mul_stage #(.WIDTH(WIDTH), .COLS(COLS), .BASE(i*COLS), .TAPS(TAPS)) u_stage (
        .clk_i, .rst_ni,
        .valid_i(v_s[i]), .alpha_i(alpha_s[i]), .sum_i(sum_s[i]), .b_i(b_s[i]),
        .valid_o(valid_o), .alpha_o(last_alpha_unused), .sum_o(prod_o), .b_o(last_b_unused)
      );
    end else begin : g_mid
      gf2m_mul_stage #(.WIDTH(WIDTH), .COLS(COLS), .BASE(i*COLS), .TAPS(TAPS)) u_stage (
        .clk_i, .rst_ni,
        .valid_i(v_s[i]), .alpha_i(alpha_s[i]), .sum_i(sum_s[i]), .b_i(b_s[i]),
        .valid_o(v_s[i+1]), .alpha_o(alpha_s[i+1]), .sum_o(sum_s[i+1]), .b_o(b_s[i+1])
      );
    end
  end
endmodule

// File: rtl/gf2m_pipe_mul_chk.sv
module gf2m_pipe_mul_chk #(
  parameter int unsigned WIDTH  = 163,
  parameter int unsigned STAGES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             valid_o,
  input logic [WIDTH-1:0] prod_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             vp [STAGES];
  logic             zp [STAGES];
  logic             ip [STAGES];
  logic [WIDTH-1:0] iv [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) begin
        vp[k] <= 1'b0; zp[k] <= 1'b0; ip[k] <= 1'b0; iv[k] <= '0;
      end
    end else begin
      vp[0] <= valid_i;
      zp[0] <= (a_i == '0) || (b_i == '0);
      ip[0] <= (a_i == ONE) || (b_i == ONE);
      iv[0] <= (b_i == ONE) ? a_i : b_i;
      for (int k = 1; k < STAGES; k++) begin
        vp[k] <= vp[k-1]; zp[k] <= zp[k-1]; ip[k] <= ip[k-1]; iv[k] <= iv[k-1];
      end
    end
  end

  // R5
  always_comb begin
    if (!rst_ni) reset_quiet_chk: assert (!valid_o);
  end

  // R3
  latency_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vp[STAGES-1]);

  // R6
  zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zp[STAGES-1]) |-> (prod_o == '0));

  // R7
  identity_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ip[STAGES-1]) |-> (prod_o == iv[STAGES-1]));
endmodule

bind gf2m_pipe_mul gf2m_pipe_mul_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
  .valid_o(valid_o), .prod_o(prod_o)
);

// File: tb/tb_gf2m_pipe_mul.sv
module tb_gf2m_pipe_mul;
  localparam int unsigned W = 163;
  localparam int unsigned D = 4;
  localparam time CLK_PERIOD = 10;
  localparam int MAXN = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         valid_o;
  logic [W-1:0] prod_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] a_arr [MAXN];
  logic [W-1:0] b_arr [MAXN];
  logic         v_arr [MAXN];

  gf2m_pipe_mul #(.STAGES(D)) dut (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .valid_o, .prod_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [W-1:0] gf_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = W-1; i >= 0; i--) begin
      r = {r[W-2:0], 1'b0} ^ (r[W-1] ? W'('hC9) : '0);
      if (b[i]) r ^= a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd();
    return W'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: valid_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: prod_o=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive entries 0..n-1 back to back; check outputs D-1 edges after sampling
  task automatic run_stream(input int n, input string req);
    for (int c = 0; c < n + D + 1; c++) begin
      @(negedge clk_i);
      if (c >= D && c - D < n && v_arr[c-D]) begin
        check_bit(req, valid_o, 1'b1);
        check_vec(req, prod_o, gf_ref(a_arr[c-D], b_arr[c-D]));
      end else if (c >= D) begin
        check_bit(req, valid_o, 1'b0);
      end
      if (c < n) begin
        valid_i = v_arr[c]; a_i = a_arr[c]; b_i = b_arr[c];
      end else begin
        valid_i = 1'b0; a_i = '0; b_i = '0;
      end
    end
  endtask

  task automatic set_entry(input int k, input logic [W-1:0] a, input logic [W-1:0] b);
    a_arr[k] = a; b_arr[k] = b; v_arr[k] = 1'b1;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/4);
    check_bit("R5 reset", valid_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (D + 1) begin
      @(negedge clk_i);
      check_bit("R5 idle after reset", valid_o, 1'b0);
    end
  endtask

  task automatic t_reduction();
    logic [W-1:0] top = W'(1) << (W-1);
    logic [W-1:0] one = W'(1);
    set_entry(0, top, one << 1);
    set_entry(1, top, top);
    set_entry(2, ~W'(0), ~W'(0));
    set_entry(3, one << 1, top);
    run_stream(4, "R1 overflow reduction");
    // x^162 * x = x^7 + x^6 + x^3 + 1
    check_vec("R1 tap pattern", gf_ref(top, one << 1), W'('hC9));
  endtask

  task automatic t_corners();
    logic [W-1:0] top = W'(1) << (W-1);
    logic [W-1:0] r = rnd();
    set_entry(0, '0, r);
    set_entry(1, r, '0);
    set_entry(2, W'(1), r);
    set_entry(3, r, W'(1));
    set_entry(4, r, top);
    set_entry(5, '0, '0);
    set_entry(6, W'(1), W'(1));
    run_stream(7, "R6 R7 corner operands");
  endtask

  task automatic t_random_burst();
    for (int k = 0; k < 40; k++) set_entry(k, rnd(), rnd());
    run_stream(40, "R2 R4 back-to-back random");
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 30; k++) begin
      set_entry(k, rnd(), rnd());
      v_arr[k] = (k % 3 != 1);
    end
    run_stream(30, "R3 R5 gapped stream");
  endtask

  task automatic t_reset_in_flight();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      valid_i = 1'b1; a_i = rnd(); b_i = rnd();
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check_bit("R5 flush on reset", valid_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (D + 1) begin
      @(negedge clk_i);
      check_bit("R5 no stale result", valid_o, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_reduction();
    t_corners();
    t_random_burst();
    t_gaps();
    t_reset_in_flight();
    t_random_burst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule